// File: doc/BRIEF.md
# Secondary Core Power Zone Sequencer

This block brings the power zone of a secondary processor core up or down. It runs a fixed order of single-bit read-modify-write steps on that core's zone control word, and it checks the zone's power status inputs after each power step. Every status poll has a timeout, set as a count of cycles. A power-up also programs the core's boot-vector word pair through a simple write port and then releases the core's halt bit. A power-down ends by setting the halt bit again.

Commands arrive as a one-cycle `cmd_valid` with a direction, a core index and a boot address. The block takes one command at a time and finishes each with one of three outcomes: `done`, `refused` (a power-down of core 0) or the sticky `tmo_err`. It drives no zone steps until a command is accepted. While an error is held, it takes no new command until `clr_err` is pulsed.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, every zone control word is 0, the halt bits are 1 for every core except core 0 (which is 0), and `busy`, `done`, `refused`, `tmo_err` and `bv_we` are all 0.
- R2: A power-up of a core whose `zone_in_reset` bit is 1 changes that core's zone word in this order, one bit per cycle: isolation set (bit 4), manual mode set (bit 5), logic enable set (bit 3), memory enable set (bit 2); wait for `zone_mem_ok`; clock enable set (bit 0); wait for `zone_logic_ok`; isolation cleared; reset release set (bit 1). Starting from 0, the final word is 6'b101111. With both status inputs already satisfied, `done` rises 13 edges after the accepting edge.
- R3: A power-up of a core whose `zone_in_reset` bit is 0 leaves the zone word unchanged and performs only the boot steps. `done` rises 4 edges after the accepting edge.
- R4: Every power-up makes two boot-vector writes. The first writes data 0 to address BV_BASE + 8*core. The second writes the boot address to BV_BASE + 8*core + 4. After both writes, the core's halt bit is cleared.
- R5: A power-down changes the zone word in this order: manual mode set, reset release cleared, clock enable cleared, isolation set, memory enable cleared; wait for `zone_mem_ok` low; logic enable cleared; wait for `zone_logic_ok` low. The core's halt bit is then set. Starting from 6'b101111, the final word is 6'b110000. With `quiesced` high and the status inputs already satisfied, `done` rises 11 edges after the accepting edge.
- R6: A power-down makes no zone change, and keeps `busy` high, until the target core's `quiesced` bit is 1.
- R7: A power-down command for core 0 pulses `refused` in the cycle after acceptance. `busy` stays low, and no zone word or halt bit changes.
- R8: A status wait samples once per cycle. If the status has not matched by the TMO_CYC+1-th sample, `tmo_err` rises on that edge. A match on that last sample lets the sequence continue.
- R9: `tmo_err` stays high with `busy` low until `clr_err`. Commands presented while it is high are ignored.
- R10: `busy` is high from the accepting edge until completion or error. Commands presented while `busy` is high are ignored.
- R11: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_up | input | 1 | 1 = power up and boot, 0 = power down |
| cmd_core | input | CW | Target core index |
| cmd_boot_addr | input | AW | Boot address for power-up |
| clr_err | input | 1 | Clears the timeout error |
| quiesced | input | NCORE | Per-core quiesced indication |
| zone_in_reset | input | NCORE | Per-core "zone is off / in reset" status |
| zone_mem_ok | input | NCORE | Per-core memory power status |
| zone_logic_ok | input | NCORE | Per-core logic power status |
| zone_ctrl | output | NCORE*6 | Per-core zone control words, core c at bits [6c+5:6c] |
| halt | output | NCORE | Per-core halt bits |
| bv_we | output | 1 | Boot-vector write strobe |
| bv_addr | output | ADW | Boot-vector byte address |
| bv_data | output | AW | Boot-vector write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed (pulse) |
| refused | output | 1 | Power-down of core 0 refused (pulse) |
| tmo_err | output | 1 | Sticky status-poll timeout |

## Verification
The checker watches several rules on every cycle. It confirms that zone words hold still whenever the block is idle, that a core-0 power-down yields `refused` with no state change, and that an error keeps the block idle. It also checks that `done` is a one-cycle pulse, that only one outcome is signalled per cycle, and that the boot-vector writes come as a pair on the 8-byte stride with a zero first word. Some behaviour only the bench scenarios can show. These cover the exact order of the zone-bit edits and the latency to `done`. They also cover the skip of zone steps for a core that is already on, holding off until quiesce, and the exact sample on which the timeout fires or is rescued by a late status match.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;
   // zone control word layout
   localparam int ZW       = 6;
   localparam int ZB_CLK   = 0;
   localparam int ZB_RST   = 1;
   localparam int ZB_MEM   = 2;
   localparam int ZB_LOGIC = 3;
   localparam int ZB_ISO   = 4;
   localparam int ZB_MAN   = 5;

   localparam int IXW        = 4;
   localparam int UP_BOOT_IX = 9;

   typedef enum logic [3:0] {
      OP_SET, OP_CLR, OP_WAIT_HI, OP_WAIT_LO, OP_WAIT_Q,
      OP_BV0, OP_BV1, OP_UNHALT, OP_HALT, OP_FIN
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [2:0] bix;
   } step_t;
endpackage

// File: rtl/cps_step_rom.sv
module cps_step_rom
   import core_pwr_pkg::*;
(
   input  logic           dir_up,
   input  logic [IXW-1:0] idx,
   output step_t          step
);
   always_comb begin
      step = '{op: OP_FIN, bix: 3'd0};
      if (dir_up) begin
         unique case (idx)
            4'd0:    step = '{op: OP_SET,     bix: 3'(ZB_ISO)};
            4'd1:    step = '{op: OP_SET,     bix: 3'(ZB_MAN)};
            4'd2:    step = '{op: OP_SET,     bix: 3'(ZB_LOGIC)};
            4'd3:    step = '{op: OP_SET,     bix: 3'(ZB_MEM)};
            4'd4:    step = '{op: OP_WAIT_HI, bix: 3'(ZB_MEM)};
            4'd5:    step = '{op: OP_SET,     bix: 3'(ZB_CLK)};
            4'd6:    step = '{op: OP_WAIT_HI, bix: 3'(ZB_LOGIC)};
            4'd7:    step = '{op: OP_CLR,     bix: 3'(ZB_ISO)};
            4'd8:    step = '{op: OP_SET,     bix: 3'(ZB_RST)};
            4'd9:    step = '{op: OP_BV0,     bix: 3'd0};
            4'd10:   step = '{op: OP_BV1,     bix: 3'd0};
            4'd11:   step = '{op: OP_UNHALT,  bix: 3'd0};
            default: step = '{op: OP_FIN,     bix: 3'd0};
         endcase
      end else begin
         unique case (idx)
            4'd0:    step = '{op: OP_WAIT_Q,  bix: 3'd0};
            4'd1:    step = '{op: OP_SET,     bix: 3'(ZB_MAN)};
            4'd2:    step = '{op: OP_CLR,     bix: 3'(ZB_RST)};
            4'd3:    step = '{op: OP_CLR,     bix: 3'(ZB_CLK)};
            4'd4:    step = '{op: OP_SET,     bix: 3'(ZB_ISO)};
            4'd5:    step = '{op: OP_CLR,     bix: 3'(ZB_MEM)};
            4'd6:    step = '{op: OP_WAIT_LO, bix: 3'(ZB_MEM)};
            4'd7:    step = '{op: OP_CLR,     bix: 3'(ZB_LOGIC)};
            4'd8:    step = '{op: OP_WAIT_LO, bix: 3'(ZB_LOGIC)};
            4'd9:    step = '{op: OP_HALT,    bix: 3'd0};
            default: step = '{op: OP_FIN,     bix: 3'd0};
         endcase
      end
   end
endmodule

// File: rtl/cps_poll_timer.sv
module cps_poll_timer #(
   parameter int TMO_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CNTW = $clog2(TMO_CYC + 1);

   logic [CNTW-1:0] cnt_q;

   assign expired = (cnt_q == CNTW'(TMO_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (run && !expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cps_zone_bank.sv
module cps_zone_bank
   import core_pwr_pkg::*;
#(
   parameter int NCORE = 4,
   localparam int CW   = $clog2(NCORE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              z_we,
   input  logic              z_val,
   input  logic [2:0]        z_bix,
   input  logic              h_we,
   input  logic              h_val,
   input  logic [CW-1:0]     core,
   output logic [NCORE*ZW-1:0] zone_ctrl,
   output logic [NCORE-1:0]  halt
);
   for (genvar c = 0; c < NCORE; c++) begin : g_core
      logic [ZW-1:0] zq;
      logic          hq;
      logic          sel;

      assign sel = (core == CW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            zq <= '0;
            hq <= (c != 0);
         end else begin
            if (z_we && sel) zq[z_bix] <= z_val;
            if (h_we && sel) hq <= h_val;
         end
      end

      assign zone_ctrl[c*ZW +: ZW] = zq;
      assign halt[c]               = hq;
   end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
   import core_pwr_pkg::*;
#(
   parameter int          NCORE   = 4,
   parameter int          AW      = 32,
   parameter int          ADW     = 16,
   parameter int unsigned BV_BASE = 32'h0000_0100,
   parameter int          TMO_CYC = 1000,
   localparam int         CW      = $clog2(NCORE)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_up,
   input  logic [CW-1:0]        cmd_core,
   input  logic [AW-1:0]        cmd_boot_addr,
   input  logic                 clr_err,
   input  logic [NCORE-1:0]     quiesced,
   input  logic [NCORE-1:0]     zone_in_reset,
   input  logic [NCORE-1:0]     zone_mem_ok,
   input  logic [NCORE-1:0]     zone_logic_ok,
   output logic [NCORE*ZW-1:0]  zone_ctrl,
   output logic [NCORE-1:0]     halt,
   output logic                 bv_we,
   output logic [ADW-1:0]       bv_addr,
   output logic [AW-1:0]        bv_data,
   output logic                 busy,
   output logic                 done,
   output logic                 refused,
   output logic                 tmo_err
);
   if (NCORE < 2 || (1 << CW) != NCORE) begin : g_bad_ncore
      $error("NCORE must be a power of two of at least 2");
   end
   if (TMO_CYC < 1) begin : g_bad_tmo
      $error("TMO_CYC must be at least 1");
   end
   if (ADW < CW + 4) begin : g_bad_adw
      $error("ADW too narrow for the boot-vector stride");
   end

   logic            busy_q, up_q, done_q, ref_q, err_q;
   logic [CW-1:0]   core_q;
   logic [AW-1:0]   addr_q;
   logic [IXW-1:0]  idx_q;
   logic            bv_we_q;
   logic [ADW-1:0]  bv_addr_q;
   logic [AW-1:0]   bv_data_q;

   step_t step;
   logic  is_wait, stat, match, expired, accept;
   logic  z_we, h_we, h_val;
   logic [ADW-1:0] pair_base;

   cps_step_rom u_rom (.dir_up(up_q), .idx(idx_q), .step(step));

   assign is_wait = busy_q && (step.op == OP_WAIT_HI || step.op == OP_WAIT_LO);
   assign stat    = (step.bix == 3'(ZB_MEM)) ? zone_mem_ok[core_q] : zone_logic_ok[core_q];
   assign match   = (step.op == OP_WAIT_HI) ? stat : !stat;

   cps_poll_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!is_wait), .run(is_wait && !match), .expired(expired)
   );

   assign z_we  = busy_q && (step.op == OP_SET || step.op == OP_CLR);
   assign h_we  = busy_q && (step.op == OP_UNHALT || step.op == OP_HALT);
   assign h_val = (step.op == OP_HALT);

   cps_zone_bank #(.NCORE(NCORE)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .z_we(z_we), .z_val(step.op == OP_SET), .z_bix(step.bix),
      .h_we(h_we), .h_val(h_val), .core(core_q),
      .zone_ctrl(zone_ctrl), .halt(halt)
   );

   assign accept    = cmd_valid && !busy_q && !err_q;
   assign pair_base = ADW'(BV_BASE) + ADW'({core_q, 3'b000});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         up_q      <= 1'b0;
         done_q    <= 1'b0;
         ref_q     <= 1'b0;
         err_q     <= 1'b0;
         core_q    <= '0;
         addr_q    <= '0;
         idx_q     <= '0;
         bv_we_q   <= 1'b0;
         bv_addr_q <= '0;
         bv_data_q <= '0;
      end else begin
         done_q  <= 1'b0;
         ref_q   <= 1'b0;
         bv_we_q <= 1'b0;
         if (err_q && clr_err) err_q <= 1'b0;
         if (!busy_q) begin
            if (accept) begin
               if (!cmd_up && cmd_core == '0) begin
                  ref_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
                  up_q   <= cmd_up;
                  core_q <= cmd_core;
                  addr_q <= cmd_boot_addr;
                  idx_q  <= (cmd_up && !zone_in_reset[cmd_core]) ? IXW'(UP_BOOT_IX) : '0;
               end
            end
         end else begin
            unique case (step.op)
               OP_WAIT_Q: if (quiesced[core_q]) idx_q <= idx_q + 1'b1;
               OP_WAIT_HI, OP_WAIT_LO: begin
                  if (match) idx_q <= idx_q + 1'b1;
                  else if (expired) begin
                     err_q  <= 1'b1;
                     busy_q <= 1'b0;
                  end
               end
               OP_BV0: begin
                  bv_we_q   <= 1'b1;
                  bv_addr_q <= pair_base;
                  bv_data_q <= '0;
                  idx_q     <= idx_q + 1'b1;
               end
               OP_BV1: begin
                  bv_we_q   <= 1'b1;
                  bv_addr_q <= pair_base + ADW'(4);
                  bv_data_q <= addr_q;
                  idx_q     <= idx_q + 1'b1;
               end
               OP_FIN: begin
                  done_q <= 1'b1;
                  busy_q <= 1'b0;
               end
               default: idx_q <= idx_q + 1'b1;
            endcase
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign refused = ref_q;
   assign tmo_err = err_q;
   assign bv_we   = bv_we_q;
   assign bv_addr = bv_addr_q;
   assign bv_data = bv_data_q;
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
   parameter int          NCORE   = 4,
   parameter int          AW      = 32,
   parameter int          ADW     = 16,
   parameter int unsigned BV_BASE = 32'h0000_0100,
   localparam int         CW      = $clog2(NCORE)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_valid,
   input logic                cmd_up,
   input logic [CW-1:0]       cmd_core,
   input logic [NCORE*6-1:0]  zone_ctrl,
   input logic [NCORE-1:0]    halt,
   input logic                bv_we,
   input logic [ADW-1:0]      bv_addr,
   input logic [AW-1:0]       bv_data,
   input logic                busy,
   input logic                done,
   input logic                refused,
   input logic                tmo_err
);
   logic [ADW-1:0] bv_off;
   assign bv_off = bv_addr - ADW'(BV_BASE);

   p_refuse_core0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !tmo_err && !cmd_up && cmd_core == '0)
      |=> (refused && !busy && $stable(zone_ctrl) && $stable(halt)));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(zone_ctrl));

   p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |=> !busy);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, refused, $rose(tmo_err)}));

   p_bv_zero_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bv_we && bv_off[2:0] == 3'd0) |-> bv_data == '0);

   p_bv_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bv_we && bv_off[2:0] == 3'd0) |=> (bv_we && bv_addr == $past(bv_addr) + ADW'(4)));
endmodule

bind core_pwr_seq core_pwr_seq_chk #(
   .NCORE(NCORE), .AW(AW), .ADW(ADW), .BV_BASE(BV_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_core(cmd_core),
   .zone_ctrl(zone_ctrl), .halt(halt), .bv_we(bv_we), .bv_addr(bv_addr), .bv_data(bv_data),
   .busy(busy), .done(done), .refused(refused), .tmo_err(tmo_err)
);

// File: tb/tb_core_pwr_seq.sv
module tb_core_pwr_seq;
   localparam int NC  = 4;
   localparam int TMO = 20;
   localparam logic [15:0] BASE = 16'h0100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_up = 1'b0, clr_err = 1'b0;
   logic [1:0]  cmd_core = '0;
   logic [31:0] cmd_boot_addr = '0;
   logic [NC-1:0] quiesced = '1, in_rst = '1, mforce = '0;
   logic [NC-1:0] mem_ok, logic_ok;
   logic [NC*6-1:0] zone_ctrl;
   logic [NC-1:0] halt;
   logic bv_we, busy, done, refused, tmo_err;
   logic [15:0] bv_addr;
   logic [31:0] bv_data;

   always #10 clk = ~clk;

   for (genvar c = 0; c < NC; c++) begin : g_model
      assign mem_ok[c]   = mforce[c] ? 1'b0 : zone_ctrl[c*6+2];
      assign logic_ok[c] = zone_ctrl[c*6+3];
   end

   core_pwr_seq #(.NCORE(NC), .AW(32), .ADW(16), .BV_BASE(32'h100), .TMO_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_core(cmd_core),
      .cmd_boot_addr(cmd_boot_addr), .clr_err(clr_err), .quiesced(quiesced),
      .zone_in_reset(in_rst), .zone_mem_ok(mem_ok), .zone_logic_ok(logic_ok),
      .zone_ctrl(zone_ctrl), .halt(halt), .bv_we(bv_we), .bv_addr(bv_addr), .bv_data(bv_data),
      .busy(busy), .done(done), .refused(refused), .tmo_err(tmo_err)
   );

   int total = 0, bad = 0;

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] zw(input int c);
      return zone_ctrl[c*6 +: 6];
   endfunction

   // zone change trace for one core and boot-vector write log
   int tr_core = 1;
   logic [5:0] trc [16];
   int trn = 0;
   logic [5:0] zprev;
   logic [15:0] wa [4];
   logic [31:0] wd [4];
   int wn = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (zw(tr_core) != zprev && trn < 16) begin
            trc[trn] = zw(tr_core);
            trn++;
         end
         zprev = zw(tr_core);
         if (bv_we && wn < 4) begin
            wa[wn] = bv_addr;
            wd[wn] = bv_data;
            wn++;
         end
      end
   end

   // presents a command for one accepting edge; returns edges until an outcome
   task automatic run_cmd(input logic up, input logic [1:0] core, input logic [31:0] a, output int lat);
      tr_core = core;
      zprev   = zw(core);
      trn = 0; wn = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = up; cmd_core = core; cmd_boot_addr = a;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 0;
      while (!(done || refused || tmo_err) && lat < 500) begin
         @(posedge clk); lat++; @(negedge clk);
      end
   endtask

   typedef struct packed {
      logic        up;
      logic [1:0]  core;
      logic        inrst;
      logic [31:0] addr;
      logic [5:0]  zone;
      logic        hlt;
      logic [4:0]  lat;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{1'b1, 2'd2, 1'b1, 32'h8000_2000, 6'b101111, 1'b0, 5'd13},
      '{1'b1, 2'd3, 1'b1, 32'h8000_3000, 6'b101111, 1'b0, 5'd13},
      '{1'b0, 2'd3, 1'b1, 32'h0,         6'b110000, 1'b1, 5'd11},
      '{1'b1, 2'd3, 1'b0, 32'h8000_3300, 6'b110000, 1'b0, 5'd4},
      '{1'b0, 2'd2, 1'b1, 32'h0,         6'b110000, 1'b1, 5'd11}
   };

   localparam logic [5:0] UP_TR [7] = '{6'b010000, 6'b110000, 6'b111000, 6'b111100,
                                        6'b111101, 6'b101101, 6'b101111};
   localparam logic [5:0] DN_TR [5] = '{6'b101101, 6'b101100, 6'b111100, 6'b111000, 6'b110000};

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lat;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(zone_ctrl == '0, "R1 zone", 32'(zone_ctrl), 0);
      chk(halt == 4'b1110, "R1 halt", 32'(halt), 32'hE);
      chk({busy, done, refused, tmo_err, bv_we} == '0, "R1 flags",
          32'({busy, done, refused, tmo_err, bv_we}), 0);

      // R2 and R4: power-up of core 1 from off, step order traced
      run_cmd(1'b1, 2'd1, 32'h8000_1000, lat);
      chk(lat == 13, "R2 latency", lat, 13);
      chk(trn == 7, "R2 trace length", trn, 7);
      for (int i = 0; i < 7; i++)
         chk(trc[i] == UP_TR[i], "R2 step order", 32'(trc[i]), 32'(UP_TR[i]));
      chk(wn == 2, "R4 write count", wn, 2);
      chk(wa[0] == BASE + 16'd8 && wd[0] == 0, "R4 first word", {wa[0], wd[0][15:0]}, {BASE + 16'd8, 16'h0});
      chk(wa[1] == BASE + 16'd12 && wd[1] == 32'h8000_1000, "R4 second word", 32'(wa[1]), 32'(BASE + 16'd12));
      chk(halt[1] == 1'b0, "R4 unhalt", 32'(halt[1]), 0);
      @(negedge clk);
      chk(done == 1'b0, "R11 done pulse", 32'(done), 0);

      // R6 then R5: power-down of core 1 waits for quiesce
      quiesced[1] = 1'b0;
      tr_core = 1; zprev = zw(1); trn = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = 1'b0; cmd_core = 2'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R6 busy while waiting", 32'(busy), 1);
      chk(zw(1) == 6'b101111, "R6 zone untouched", 32'(zw(1)), 32'h2F);
      quiesced[1] = 1'b1;
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      chk(done == 1'b1, "R5 down done", 32'(done), 1);
      chk(trn == 5, "R5 trace length", trn, 5);
      for (int i = 0; i < 5; i++)
         chk(trc[i] == DN_TR[i], "R5 step order", 32'(trc[i]), 32'(DN_TR[i]));
      chk(halt[1] == 1'b1, "R5 halt set", 32'(halt[1]), 1);

      // vector table: R2, R3, R4, R5
      for (int v = 0; v < 5; v++) begin
         in_rst[VEC[v].core] = VEC[v].inrst;
         run_cmd(VEC[v].up, VEC[v].core, VEC[v].addr, lat);
         chk(lat == int'(VEC[v].lat), "R2/R3/R5 latency", lat, 32'(VEC[v].lat));
         chk(zw(VEC[v].core) == VEC[v].zone, "R2/R3/R5 final zone", 32'(zw(VEC[v].core)), 32'(VEC[v].zone));
         chk(halt[VEC[v].core] == VEC[v].hlt, "R4/R5 halt", 32'(halt[VEC[v].core]), 32'(VEC[v].hlt));
         if (VEC[v].up)
            chk(wn == 2 && wd[1] == VEC[v].addr &&
                wa[1] == BASE + 16'(8 * VEC[v].core) + 16'd4, "R4 pair", wd[1], VEC[v].addr);
         in_rst[VEC[v].core] = 1'b1;
      end

      // R7: power-down of core 0 refused
      run_cmd(1'b0, 2'd0, 32'h0, lat);
      chk(refused == 1'b1 && lat == 0, "R7 refused", 32'(refused), 1);
      chk(busy == 1'b0, "R7 not busy", 32'(busy), 0);
      chk(zw(0) == 6'b0 && halt[0] == 1'b0, "R7 core0 unchanged", 32'({halt[0], zw(0)}), 0);

      // R10: command while busy is ignored
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = 1'b1; cmd_core = 2'd2;
      @(negedge clk);
      cmd_core = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy", 32'(busy), 1);
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      chk(zw(2) == 6'b101111, "R10 first command completes", 32'(zw(2)), 32'h2F);
      repeat (3) @(negedge clk);
      chk(zw(3) == 6'b110000, "R10 second command ignored", 32'(zw(3)), 32'h30);

      // R8: timeout on memory status for core 3
      mforce[3] = 1'b1;
      tr_core = 3; zprev = zw(3);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = 1'b1; cmd_core = 2'd3;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (4 + TMO) @(negedge clk);
      chk(tmo_err == 1'b0, "R8 no error before last sample", 32'(tmo_err), 0);
      @(negedge clk);
      chk(tmo_err == 1'b1, "R8 error on last sample", 32'(tmo_err), 1);
      chk(busy == 1'b0, "R9 idle on error", 32'(busy), 0);

      // R9: commands ignored while error held
      mforce[3] = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = 1'b1; cmd_core = 2'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && zw(1) == 6'b110000, "R9 command ignored", 32'(zw(1)), 32'h30);
      chk(tmo_err == 1'b1, "R9 error sticky", 32'(tmo_err), 1);
      clr_err = 1'b1;
      @(negedge clk);
      clr_err = 1'b0;
      chk(tmo_err == 1'b0, "R9 cleared", 32'(tmo_err), 0);

      // R8: status arriving on the final sample rescues the wait
      mforce[3] = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_up = 1'b1; cmd_core = 2'd3;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (4 + TMO) @(negedge clk);
      mforce[3] = 1'b0;
      lat = 0;
      while (!done && !tmo_err && lat < 100) begin @(negedge clk); lat++; end
      chk(done == 1'b1 && tmo_err == 1'b0, "R8 final sample match", 32'({done, tmo_err}), 32'h2);
      chk(zw(3) == 6'b101111, "R8 sequence completes", 32'(zw(3)), 32'h2F);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule